// File: doc/BRIEF.md
# Serial Configuration Stream Framing Checker

The block takes a configuration stream one bit per clock and checks its framing as the bits arrive. It waits for a lead-in of at least eight ones followed by a four-bit preamble, captures a 24-bit length field, and checks a four-bit all-ones separator. It then walks a fixed number of frames. Each frame has a start bit, a parameterised number of payload bits and a four-bit check field. After the last frame it checks an eight-bit postamble.

Payload bits are passed out in arrival order with a valid strobe. The check field is either a fixed constant or a four-bit CRC over the frame's payload, chosen by a mode input. The block counts stream bits and compares the count against the captured length. After a clean postamble it counts four start-up clocks, whose bits are ignored, and then pulses done. Any framing fault sets a sticky flag and sends the parser back to searching for a new lead-in.

Top module: `cfg_stream_parser`

## Requirements
- R1: A stream is recognised only after at least 8 consecutive ones followed by the bits 0,0,1,0. A run of fewer than 8 ones followed by a 0 is discarded silently, with no flag and no output.
- R2: If the bits after the lead-in differ from 0,0,1,0, `err_header` is set and the parser returns to lead-in search.
- R3: The 24 bits after the preamble are captured most-significant bit first into `len_count`. `len_vld` pulses for one cycle in the cycle after the last length bit.
- R4: The 4 bits after the length must all be 1; otherwise `err_header` is set and search resumes.
- R5: Each frame's first bit must be 0; otherwise `err_frame` is set and search resumes.
- R6: Each of the DATA_W payload bits appears on `frame_bit`, with `frame_bit_vld` high, one cycle after it is received, in received order.
- R7: With `crc_mode`=0, the 4 check bits must be 0,1,1,0 in arrival order; otherwise `err_frame` is set.
- R8: With `crc_mode`=1, the check bits (MSB first) must equal a CRC-4 over the frame's payload. The CRC starts at 0 each frame and steps per bit as fb=crc[3]^bit, crc={crc[2:0],0}^(fb?CRC_POLY:0); the default CRC_POLY is 4'b0011. A mismatch sets `err_frame`.
- R9: After FRAMES frames, the 8 bits must be 0,1,1,1,1,1,1,1; otherwise `err_post` is set and no done follows.
- R10: The number of bits from the first preamble bit through the last postamble bit, inclusive, must equal `len_count`. Otherwise `err_length` is set and no done follows.
- R11: After a valid postamble, `done` is a one-cycle pulse registered at the clock edge of the 4th following bit, and the bits in those 4 cycles are ignored. `startup_cnt` counts 1 to 4 over those clocks and then holds 4.
- R12: All error flags are sticky until reset and read 0 after reset. After an error, a later well-formed stream is still parsed to done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, one stream bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bit | input | 1 | Serial stream bit |
| crc_mode | input | 1 | 0: constant check field, 1: CRC-4 check field |
| frame_bit | output | 1 | Payload bit |
| frame_bit_vld | output | 1 | Payload bit valid |
| len_count | output | 24 | Captured length field |
| len_vld | output | 1 | One-cycle pulse when length captured |
| done | output | 1 | One-cycle end-of-configuration pulse |
| startup_cnt | output | 3 | Start-up clocks counted after postamble |
| err_header | output | 1 | Sticky preamble/separator fault |
| err_frame | output | 1 | Sticky start-bit/check-field fault |
| err_post | output | 1 | Sticky postamble fault |
| err_length | output | 1 | Sticky length mismatch |

## Verification
A wrong field index or state shows at the ports within one frame. Payload bits come out shifted or dropped, or a flag rises on a well-formed stream, or the done pulse is missing. An off-by-one in the bit counter or the start-up timer moves done by a cycle or raises `err_length`, so the bench compares the exact cycle of done against the cycle of the last postamble bit. A corrupted CRC state appears as a false `err_frame` at the end of the affected frame in CRC mode. Each fault class is injected once to show that its flag rises and done is withheld.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
    typedef enum logic [3:0] {
        ST_SEARCH = 4'd0,
        ST_PRE    = 4'd1,
        ST_LEN    = 4'd2,
        ST_SEP    = 4'd3,
        ST_START  = 4'd4,
        ST_DATA   = 4'd5,
        ST_CHK    = 4'd6,
        ST_POST   = 4'd7,
        ST_WAIT   = 4'd8
    } pst_e;

    localparam int         LEAD_ONES  = 8;
    localparam int         LEN_W      = 24;
    localparam int         START_CLKS = 4;
    localparam logic [3:0] PRE_CODE   = 4'b0010;
    localparam logic [3:0] CONST_CHK  = 4'b0110;
    localparam logic [7:0] POST_CODE  = 8'b0111_1111;
endpackage

// File: rtl/cfg_crc4.sv
module cfg_crc4 #(
    parameter logic [3:0] POLY = 4'b0011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       shift,
    input  logic       bit_in,
    output logic [3:0] crc
);
    logic [3:0] crc_d, crc_q;
    logic       fb;

    always_comb begin
        crc_d = crc_q;
        fb    = crc_q[3] ^ bit_in;
        if (clr)
            crc_d = 4'b0;
        else if (shift)
            crc_d = {crc_q[2:0], 1'b0} ^ (fb ? POLY : 4'b0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= 4'b0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    // R8: a cleared register reads zero on the following cycle
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == 4'b0));
endmodule

// File: rtl/cfg_startup_timer.sv
module cfg_startup_timer #(
    parameter int CLKS = 4,
    localparam int CW  = $clog2(CLKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    output logic [CW-1:0] cnt,
    output logic          last,
    output logic          fire
);
    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic          fire;
    } tmr_t;

    tmr_t tm_d, tm_q;

    always_comb begin
        tm_d      = tm_q;
        tm_d.fire = 1'b0;
        if (arm) begin
            tm_d.run = 1'b1;
            tm_d.cnt = '0;
        end else if (tm_q.run) begin
            tm_d.cnt = tm_q.cnt + 1'b1;
            if (tm_q.cnt == CW'(CLKS - 1)) begin
                tm_d.run  = 1'b0;
                tm_d.fire = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign cnt  = tm_q.cnt;
    assign fire = tm_q.fire;
    assign last = tm_q.run && (tm_q.cnt == CW'(CLKS - 1));

    a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tm_q.cnt <= CW'(CLKS));
    a_r11_fire_follows_run: assert property (@(posedge clk) disable iff (!rst_n)
        tm_q.fire |-> $past(tm_q.run));
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
    import cfg_stream_pkg::*;
#(
    parameter int         DATA_W   = 16,
    parameter int         FRAMES   = 3,
    parameter logic [3:0] CRC_POLY = 4'b0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bit,
    input  logic              crc_mode,
    output logic              frame_bit,
    output logic              frame_bit_vld,
    output logic [LEN_W-1:0]  len_count,
    output logic              len_vld,
    output logic              done,
    output logic [$clog2(START_CLKS+1)-1:0] startup_cnt,
    output logic              err_header,
    output logic              err_frame,
    output logic              err_post,
    output logic              err_length
);
    localparam int IW = $clog2(DATA_W > LEN_W ? DATA_W : LEN_W) + 1;
    localparam int FW = (FRAMES > 1) ? $clog2(FRAMES) : 1;

    typedef struct packed {
        pst_e             st;
        logic [3:0]       ones;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] bcnt;
        logic [IW-1:0]    idx;
        logic [FW-1:0]    frm;
        logic             bad;
        logic             dbit;
        logic             dvld;
        logic             lvld;
        logic             e_hdr;
        logic             e_frm;
        logic             e_post;
        logic             e_len;
    } regs_t;

    regs_t q, d;

    logic [3:0]       crc_val, chk_exp;
    logic             crc_clr, crc_shift, arm, tm_last;
    logic [1:0]       i2;
    logic [2:0]       i3;
    logic [LEN_W-1:0] total;

    assign i2      = q.idx[1:0];
    assign i3      = q.idx[2:0];
    assign total   = q.bcnt + 1'b1;
    assign chk_exp = crc_mode ? crc_val : CONST_CHK;
    assign crc_clr   = (q.st == ST_START);
    assign crc_shift = (q.st == ST_DATA);

    always_comb begin
        d      = q;
        d.dvld = 1'b0;
        d.lvld = 1'b0;
        arm    = 1'b0;
        if (q.st != ST_SEARCH && q.st != ST_WAIT)
            d.bcnt = q.bcnt + 1'b1;
        case (q.st)
            ST_SEARCH: begin
                if (cfg_bit) begin
                    if (q.ones < 4'(LEAD_ONES)) d.ones = q.ones + 1'b1;
                end else if (q.ones >= 4'(LEAD_ONES)) begin
                    d.st   = ST_PRE;
                    d.idx  = IW'(1);
                    d.bcnt = LEN_W'(1);
                    d.ones = '0;
                end else begin
                    d.ones = '0;
                end
            end
            ST_PRE: begin
                d.idx = q.idx + 1'b1;
                if (cfg_bit != PRE_CODE[2'd3 - i2]) begin
                    d.e_hdr = 1'b1;
                    d.st    = ST_SEARCH;
                end else if (i2 == 2'd3) begin
                    d.st  = ST_LEN;
                    d.idx = '0;
                end
            end
            ST_LEN: begin
                d.len = {q.len[LEN_W-2:0], cfg_bit};
                d.idx = q.idx + 1'b1;
                if (q.idx == IW'(LEN_W - 1)) begin
                    d.lvld = 1'b1;
                    d.st   = ST_SEP;
                    d.idx  = '0;
                end
            end
            ST_SEP: begin
                d.idx = q.idx + 1'b1;
                if (!cfg_bit) begin
                    d.e_hdr = 1'b1;
                    d.st    = ST_SEARCH;
                end else if (i2 == 2'd3) begin
                    d.st  = ST_START;
                    d.frm = '0;
                end
            end
            ST_START: begin
                d.idx = '0;
                if (cfg_bit) begin
                    d.e_frm = 1'b1;
                    d.st    = ST_SEARCH;
                end else begin
                    d.st = ST_DATA;
                end
            end
            ST_DATA: begin
                d.dbit = cfg_bit;
                d.dvld = 1'b1;
                d.idx  = q.idx + 1'b1;
                if (q.idx == IW'(DATA_W - 1)) begin
                    d.st  = ST_CHK;
                    d.idx = '0;
                    d.bad = 1'b0;
                end
            end
            ST_CHK: begin
                d.idx = q.idx + 1'b1;
                d.bad = q.bad | (cfg_bit != chk_exp[2'd3 - i2]);
                if (i2 == 2'd3) begin
                    d.idx = '0;
                    if (d.bad) begin
                        d.e_frm = 1'b1;
                        d.st    = ST_SEARCH;
                    end else if (q.frm == FW'(FRAMES - 1)) begin
                        d.st = ST_POST;
                    end else begin
                        d.st  = ST_START;
                        d.frm = q.frm + 1'b1;
                    end
                end
            end
            ST_POST: begin
                d.idx = q.idx + 1'b1;
                if (cfg_bit != POST_CODE[3'd7 - i3]) begin
                    d.e_post = 1'b1;
                    d.st     = ST_SEARCH;
                end else if (i3 == 3'd7) begin
                    if (total != q.len) begin
                        d.e_len = 1'b1;
                        d.st    = ST_SEARCH;
                    end else begin
                        arm  = 1'b1;
                        d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (tm_last) d.st = ST_SEARCH;
            end
            default: d.st = ST_SEARCH;
        endcase
        if (d.st == ST_SEARCH && q.st != ST_SEARCH) d.ones = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    cfg_crc4 #(.POLY(CRC_POLY)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (crc_clr),
        .shift  (crc_shift),
        .bit_in (cfg_bit),
        .crc    (crc_val)
    );

    cfg_startup_timer #(.CLKS(START_CLKS)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (arm),
        .cnt  (startup_cnt),
        .last (tm_last),
        .fire (done)
    );

    assign frame_bit     = q.dbit;
    assign frame_bit_vld = q.dvld;
    assign len_count     = q.len;
    assign len_vld       = q.lvld;
    assign err_header    = q.e_hdr;
    assign err_frame     = q.e_frm;
    assign err_post      = q.e_post;
    assign err_length    = q.e_len;

    a_r6_vld_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        frame_bit_vld |-> $past(q.st) == ST_DATA);
    a_r3_len_after_field: assert property (@(posedge clk) disable iff (!rst_n)
        len_vld |-> $past(q.st) == ST_LEN);
    a_r11_done_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(q.st) == ST_WAIT);
    a_r12_hdr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_header |=> err_header);
    a_r12_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |=> err_frame);
    a_r12_post_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_post |=> err_post);
    a_r12_length_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_length |=> err_length);
    a_r10_len_err_from_post: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_length) |-> $past(q.st) == ST_POST);
endmodule

// File: tb/cfg_stream_parser_test.sv
module cfg_stream_parser_test;
    localparam int         DW   = 16;
    localparam int         NF   = 3;
    localparam logic [3:0] POLY = 4'b0011;
    localparam int         LTOT = 4 + 24 + 4 + NF * (DW + 5) + 8;

    logic        clk = 1'b0, rst_n = 1'b0, din = 1'b0, mode = 1'b0;
    logic        fbit, fvld, lvld, done, e_hdr, e_frm, e_post, e_len;
    logic [23:0] lcnt;
    logic [2:0]  su;

    cfg_stream_parser #(.DATA_W(DW), .FRAMES(NF), .CRC_POLY(POLY)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_bit(din), .crc_mode(mode),
        .frame_bit(fbit), .frame_bit_vld(fvld), .len_count(lcnt), .len_vld(lvld),
        .done(done), .startup_cnt(su), .err_header(e_hdr), .err_frame(e_frm),
        .err_post(e_post), .err_length(e_len)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0;
    bit q[$];
    bit exp_q[$];
    bit cap_q[$];
    int post_idx = -1, c0 = 0, done_cnt = 0, done_cyc = 0, lvld_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (fvld) cap_q.push_back(fbit);
            if (lvld) lvld_cnt++;
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        din   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete();
        cap_q.delete();
        done_cnt = 0;
        lvld_cnt = 0;
    endtask

    // corrupt: 0 none, 1 preamble, 2 separator, 3 start bit, 4 check, 5 postamble
    task automatic build(input bit m, input int corrupt, input int ldelta);
        logic [3:0]  pre, sep, crc, chkv;
        logic [7:0]  post;
        logic [23:0] lv;
        bit          b, fb;
        int          lead;
        q.delete();
        repeat (64) q.push_back(1'b0);
        lead = 8 + int'($urandom % 4);
        repeat (lead) q.push_back(1'b1);
        pre = 4'b0010;
        if (corrupt == 1) pre[1] = 1'b0;
        for (int i = 3; i >= 0; i--) q.push_back(pre[i]);
        lv = 24'(LTOT + ldelta);
        for (int i = 23; i >= 0; i--) q.push_back(lv[i]);
        sep = 4'hF;
        if (corrupt == 2) sep[3] = 1'b0;
        for (int i = 3; i >= 0; i--) q.push_back(sep[i]);
        for (int f = 0; f < NF; f++) begin
            q.push_back(corrupt == 3 && f == 1);
            crc = 4'b0;
            for (int k = 0; k < DW; k++) begin
                b = bit'($urandom % 2);
                q.push_back(b);
                if (corrupt == 0) exp_q.push_back(b);
                fb  = crc[3] ^ b;
                crc = {crc[2:0], 1'b0} ^ (fb ? POLY : 4'b0);
            end
            chkv = m ? crc : 4'b0110;
            if (corrupt == 4 && f == 0) chkv[2] = ~chkv[2];
            for (int i = 3; i >= 0; i--) q.push_back(chkv[i]);
        end
        post = 8'b0111_1111;
        if (corrupt == 5) post[7] = 1'b1;
        for (int i = 7; i >= 0; i--) q.push_back(post[i]);
        post_idx = q.size() - 1;
        for (int i = 0; i < 4; i++) q.push_back(corrupt == 5 ? 1'b0 : bit'($urandom % 2));
    endtask

    task automatic run_stream(input bit m);
        @(negedge clk);
        mode = m;
        for (int i = 0; i < q.size(); i++) begin
            @(negedge clk);
            din = q[i];
            if (i == post_idx) c0 = cyc;
        end
        repeat (8) begin
            @(negedge clk);
            din = 1'b0;
        end
    endtask

    task automatic good_check(input string tag, input int dn_before);
        int mism = 0;
        if (cap_q.size() != exp_q.size()) mism = 1000;
        else foreach (exp_q[i]) if (cap_q[i] != exp_q[i]) mism++;
        check(mism == 0, {tag, " R6 payload order"}, mism, 0);
        check(lcnt == 24'(LTOT), {tag, " R3 length"}, int'(lcnt), LTOT);
        check(done_cnt == dn_before + 1, {tag, " R11 done count"}, done_cnt, dn_before + 1);
        check(done_cyc == c0 + 5, {tag, " R11 done timing"}, done_cyc, c0 + 5);
        check(su == 3'd4, {tag, " R11 startup count"}, int'(su), 4);
        cap_q.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        @(negedge clk);
        check({e_hdr, e_frm, e_post, e_len, done, fvld, lvld} == 7'b0,
              "R12 reset state", int'({e_hdr, e_frm, e_post, e_len, done, fvld, lvld}), 0);

        // R7 constant check, then random mix of modes (R8)
        build(1'b0, 0, 0);
        run_stream(1'b0);
        check(lvld_cnt == 1, "R3 len_vld pulses", lvld_cnt, 1);
        check({e_hdr, e_frm, e_post, e_len} == 4'b0, "R7 no error const mode",
              int'({e_hdr, e_frm, e_post, e_len}), 0);
        good_check("R7 const", 0);
        for (int it = 0; it < 5; it++) begin
            bit m = bit'($urandom % 2);
            build(m, 0, 0);
            run_stream(m);
            check(e_frm == 1'b0, "R8 no check error", int'(e_frm), 0);
            good_check("R8 random", it + 1);
        end

        // R1 short lead-in ignored
        do_reset();
        q.delete();
        repeat (64) q.push_back(1'b0);
        repeat (7) q.push_back(1'b1);
        q.push_back(0); q.push_back(0); q.push_back(1); q.push_back(0);
        repeat (40) q.push_back(1'b0);
        post_idx = -1;
        run_stream(1'b0);
        check(cap_q.size() == 0 && lvld_cnt == 0, "R1 short lead-in no output",
              cap_q.size() + lvld_cnt, 0);
        check({e_hdr, e_frm, e_post, e_len} == 4'b0, "R1 short lead-in no flag",
              int'({e_hdr, e_frm, e_post, e_len}), 0);
        build(1'b1, 0, 0);
        run_stream(1'b1);
        good_check("R1 after short lead-in", 0);

        // R2 bad preamble, then R12 recovery with sticky flag
        do_reset();
        build(1'b0, 1, 0);
        run_stream(1'b0);
        check(e_hdr == 1'b1, "R2 preamble flag", int'(e_hdr), 1);
        check(done_cnt == 0, "R2 no done", done_cnt, 0);
        cap_q.delete();
        build(1'b0, 0, 0);
        run_stream(1'b0);
        good_check("R12 recovery", 0);
        check(e_hdr == 1'b1, "R12 flag sticky", int'(e_hdr), 1);

        do_reset();
        build(1'b0, 2, 0);
        run_stream(1'b0);
        check(e_hdr == 1'b1, "R4 separator flag", int'(e_hdr), 1);
        check(done_cnt == 0, "R4 no done", done_cnt, 0);

        do_reset();
        build(1'b1, 3, 0);
        run_stream(1'b1);
        check(e_frm == 1'b1, "R5 start bit flag", int'(e_frm), 1);

        do_reset();
        build(1'b0, 4, 0);
        run_stream(1'b0);
        check(e_frm == 1'b1, "R7 bad constant flag", int'(e_frm), 1);

        do_reset();
        build(1'b1, 4, 0);
        run_stream(1'b1);
        check(e_frm == 1'b1, "R8 bad CRC flag", int'(e_frm), 1);

        do_reset();
        build(1'b0, 0, 0);
        run_stream(1'b1);
        check(e_frm == 1'b1, "R8 constant rejected in CRC mode", int'(e_frm), 1);

        do_reset();
        build(1'b0, 5, 0);
        run_stream(1'b0);
        check(e_post == 1'b1, "R9 postamble flag", int'(e_post), 1);
        check(done_cnt == 0, "R9 no done", done_cnt, 0);

        do_reset();
        build(1'b0, 0, 1);
        run_stream(1'b0);
        check(e_len == 1'b1, "R10 length flag", int'(e_len), 1);
        check(done_cnt == 0, "R10 no done", done_cnt, 0);

        do_reset();
        build(1'b1, 0, -1);
        run_stream(1'b1);
        check(e_len == 1'b1 && done_cnt == 0, "R10 short length", int'(e_len), 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule